// File: doc/BRIEF.md
# Majority-Vote Oversampling Serial Receiver

This block receives asynchronous serial frames of one start bit, eight data bits sent least significant bit first, and one stop bit. Its timing comes from an oversampling tick, a one-cycle enable pulse that an external baud timer produces sixteen times per bit. The serial line first passes through a two-flop synchronizer. A falling edge on the synchronized line, seen while the receiver is idle, starts a sixteen-position phase counter from zero. Each bit is then sampled at phases 7, 8 and 9, and the bit value is the majority of those three samples.

The controller has four named states. In `RX_IDLE` the phase counter is held at zero. The transition `IDLE->START` fires on a falling edge. In `RX_START` the start bit is voted at phase 10: `START->IDLE` fires on a false start, and `START->DATA` fires on a valid start. In `RX_DATA` one voted bit is shifted in at each phase 10, and `DATA->STOP` fires after the eighth bit. In `RX_STOP` the stop bit is voted, and `STOP->IDLE` fires at phase 10 together with the completion decision.

On completion, the byte and the voted stop bit move into an output holding register, and the ready flag is set. This happens only when the ready flag is clear and the stop-bit filter allows it. When the filter input is high, the stop bit must be 1. Otherwise the frame is dropped and the outputs are left unchanged. The host reads the holding register while the next frame is being shifted in, and then clears the flag with a one-cycle pulse.

Top module: `uart_vote_rx`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `rx_data` is 0x00, `rx_stop` is 0 and `rx_ready` is 0.
- R2: A 1-to-0 change of the synchronized serial line starts a frame only in the idle state. Falling edges inside a frame, such as those between data bits, do not restart it.
- R3: Each bit value is the majority of three samples taken at phase counter values 7, 8 and 9. A disturbance that changes only one of the three samples does not change the bit.
- R4: If two or more of the start-bit samples are 1, the receiver returns to idle at phase 10. The outputs do not change, and a following valid frame is received normally.
- R5: The eight data bits are assembled least significant bit first. The first data bit after the start bit lands in `rx_data[0]`.
- R6: At phase 10 of the stop-bit period, an accepted frame writes the byte to `rx_data` and the voted stop bit to `rx_stop`, and sets `rx_ready`.
- R7: A frame that completes while `rx_ready` is 1 is dropped. `rx_data`, `rx_stop` and `rx_ready` keep their values.
- R8: With `stop_filter_en` at 1, a frame whose voted stop bit is 0 is dropped, leaving all outputs unchanged. A frame whose voted stop bit is 1 is accepted.
- R9: With `stop_filter_en` at 0, a frame is accepted whatever its stop bit, and `rx_stop` shows the voted stop bit.
- R10: A one-cycle `ready_clr` pulse clears `rx_ready` on the next edge and has no other effect.
- R11: The phase counter advances only on cycles with `tick_en` high, so frame timing scales with the tick period.
- R12: `rx_data` keeps the previous byte while the next frame is being shifted in, until that frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Oversampling tick, sixteen per bit time |
| rxd_in | input | 1 | Asynchronous serial input, idles high |
| stop_filter_en | input | 1 | When 1, only frames with stop bit 1 are accepted |
| ready_clr | input | 1 | One-cycle pulse that clears `rx_ready` |
| rx_data | output | 8 | Holding register for the last accepted byte |
| rx_stop | output | 1 | Voted stop bit of the last accepted frame |
| rx_ready | output | 1 | Set when a byte is accepted |

## Verification
The hardest case to reach from the ports is a disturbance that changes exactly one of the three votes. The sample instants depend on the synchronizer delay and on the phase of the free-running tick. The bench therefore makes each disturbance exactly one tick period wide, so it can cover at most one sample, and places it in the middle of the sampling window. A short low pulse that stays clear of the window provides the false start. The overrun and filter-drop cases are reached by leaving the ready flag set, or by sending a zero stop bit, and then checking that the holding register still shows the earlier byte.

// File: rtl/uart_vote_rx_pkg.sv
package uart_vote_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain[STAGES-1];
    end

    assign dout = chain[STAGES-1];
    assign fall = prev_q & ~chain[STAGES-1];

    // R2: an edge is reported only when the previous line level was high
    a_r2_fall_after_high: assert property (@(posedge clk) disable iff (rst)
        fall |-> $past(dout));
endmodule

// File: rtl/rx_vote3.sv
module rx_vote3 (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic din,
    output logic majority
);
    logic [2:0] samp_q;

    always_ff @(posedge clk) begin
        if (rst)            samp_q <= 3'b111;
        else if (sample_en) samp_q <= {samp_q[1:0], din};
    end

    always_comb begin
        majority = (samp_q[0] & samp_q[1]) | (samp_q[1] & samp_q[2]) | (samp_q[0] & samp_q[2]);
    end

    // R3: the stored samples change only when a sample is taken
    a_r3_samples_hold: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(samp_q));
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
    import uart_vote_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16,
    parameter int MID       = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic fall,
    input  logic vote,
    output logic sample_en,
    output logic shift_en,
    output logic done
);
    localparam int CW       = $clog2(OSR);
    localparam int BW       = $clog2(DATA_BITS);
    localparam int S_FIRST  = MID - 1;
    localparam int S_LAST   = MID + 1;
    localparam int DECIDE   = MID + 2;

    rx_state_t      state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [BW-1:0]  bit_q;
    logic           decide;
    logic           in_window;

    assign decide    = tick_en && (32'(cnt_q) == DECIDE);
    assign in_window = (32'(cnt_q) >= S_FIRST) && (32'(cnt_q) <= S_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (fall)   state_d = RX_START;
            RX_START: if (decide) state_d = vote ? RX_IDLE : RX_DATA;
            RX_DATA:  if (decide && (32'(bit_q) == DATA_BITS - 1)) state_d = RX_STOP;
            RX_STOP:  if (decide) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // phase counter and bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            bit_q <= '0;
        end else begin
            if (state_q == RX_IDLE) begin
                cnt_q <= '0;
            end else if (tick_en) begin
                cnt_q <= (32'(cnt_q) == OSR - 1) ? '0 : cnt_q + 1'b1;
            end
            if (state_q != RX_DATA) begin
                bit_q <= '0;
            end else if (decide) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sample_en = 1'b0;
        shift_en  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            RX_IDLE:  ;
            RX_START: sample_en = tick_en && in_window;
            RX_DATA: begin
                sample_en = tick_en && in_window;
                shift_en  = decide;
            end
            RX_STOP: begin
                sample_en = tick_en && in_window;
                done      = decide;
            end
            default: ;
        endcase
    end

    // R2: idle is left only through a falling edge
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_IDLE && !fall) |=> state_q == RX_IDLE);
    // R4: a start bit voted high aborts the frame
    a_r4_false_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_START && decide && vote) |=> state_q == RX_IDLE);
    // R11: the phase counter stands still between ticks
    a_r11_tick_gate: assert property (@(posedge clk) disable iff (rst)
        (state_q != RX_IDLE && !tick_en) |=> $stable(cnt_q));
    // R2: a frame in progress is not restarted by an edge
    a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_DATA && !decide) |=> state_q == RX_DATA);
endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic                 shift_bit,
    input  logic                 done,
    input  logic                 stop_in,
    input  logic                 filter_en,
    input  logic                 ready_clr,
    output logic [DATA_BITS-1:0] data_q,
    output logic                 stop_q,
    output logic                 ready_q
);
    logic [DATA_BITS-1:0] shreg_q;
    logic                 accept;

    assign accept = done && !ready_q && (!filter_en || stop_in);

    always_ff @(posedge clk) begin
        if (rst) shreg_q <= '0;
        else if (shift_en) shreg_q <= {shift_bit, shreg_q[DATA_BITS-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            stop_q  <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            if (accept) begin
                data_q  <= shreg_q;
                stop_q  <= stop_in;
                ready_q <= 1'b1;
            end else if (ready_clr) begin
                ready_q <= 1'b0;
            end
        end
    end

    // R7: while the flag is set and not cleared, the holding register is frozen
    a_r7_overrun_hold: assert property (@(posedge clk) disable iff (rst)
        (ready_q && !ready_clr) |=> ($stable(data_q) && $stable(stop_q) && ready_q));
    // R8: the filter drops a frame whose stop bit is 0
    a_r8_filter_drop: assert property (@(posedge clk) disable iff (rst)
        (done && filter_en && !stop_in) |=> ($stable(data_q) && $stable(ready_q)));
    // R6: the flag rises only on a completion
    a_r6_ready_source: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> $past(done));
    // R10: a clear pulse without a completion drops the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (ready_clr && !done) |=> !ready_q);
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int MID         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 rxd_in,
    input  logic                 stop_filter_en,
    input  logic                 ready_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_stop,
    output logic                 rx_ready
);
    logic line_s;
    logic fall;
    logic sample_en;
    logic shift_en;
    logic done;
    logic vote;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd_in),
        .dout (line_s),
        .fall (fall)
    );

    rx_vote3 u_vote (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .din       (line_s),
        .majority  (vote)
    );

    rx_frame_ctrl #(.DATA_BITS(DATA_BITS), .OSR(OSR), .MID(MID)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .fall      (fall),
        .vote      (vote),
        .sample_en (sample_en),
        .shift_en  (shift_en),
        .done      (done)
    );

    rx_hold_buf #(.DATA_BITS(DATA_BITS)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .shift_bit (vote),
        .done      (done),
        .stop_in   (vote),
        .filter_en (stop_filter_en),
        .ready_clr (ready_clr),
        .data_q    (rx_data),
        .stop_q    (rx_stop),
        .ready_q   (rx_ready)
    );
endmodule

// File: tb/test_uart_vote_rx.sv
module test_uart_vote_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       rxd_in = 1'b1;
    logic       stop_filter_en = 1'b0;
    logic       ready_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_stop;
    logic       rx_ready;

    int vectors = 0;
    int misses  = 0;
    int tick_div = 2;
    int tcnt = 0;

    always #4 clk = ~clk;

    uart_vote_rx i_uart_vote_rx (
        .clk            (clk),
        .rst            (rst),
        .tick_en        (tick_en),
        .rxd_in         (rxd_in),
        .stop_filter_en (stop_filter_en),
        .ready_clr      (ready_clr),
        .rx_data        (rx_data),
        .rx_stop        (rx_stop),
        .rx_ready       (rx_ready)
    );

    always @(negedge clk) begin
        if (tcnt >= tick_div - 1) begin
            tcnt    <= 0;
            tick_en <= 1'b1;
        end else begin
            tcnt    <= tcnt + 1;
            tick_en <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v);
        rxd_in = v;
        repeat (16 * tick_div) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stopb);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit(stopb);
        rxd_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic clear_ready();
        ready_clr = 1'b1;
        @(negedge clk);
        ready_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 data", 32'(rx_data), 32'h00);
        check("R1 stop", 32'(rx_stop), 32'h0);
        check("R1 ready", 32'(rx_ready), 32'h0);

        // R4 false start: short low pulse misses the sampling window
        rxd_in = 1'b0;
        repeat (4) @(negedge clk);
        rxd_in = 1'b1;
        repeat (60) @(negedge clk);
        check("R4 false start ready", 32'(rx_ready), 32'h0);
        check("R4 false start data", 32'(rx_data), 32'h00);
        send_frame(8'hA5, 1'b1);
        check("R4 recovery data", 32'(rx_data), 32'hA5);
        check("R4 recovery ready", 32'(rx_ready), 32'h1);
        clear_ready();

        // R5 R6 R2 sweep of every byte, filter toggled (stop bit 1 always accepted, R8)
        for (int b = 0; b < 256; b++) begin
            stop_filter_en = b[0];
            send_frame(8'(b), 1'b1);
            check("R5 R2 sweep data", 32'(rx_data), 32'(b));
            check("R6 sweep stop", 32'(rx_stop), 32'h1);
            check("R6 R8 sweep ready", 32'(rx_ready), 32'h1);
            clear_ready();
            check("R10 clear", 32'(rx_ready), 32'h0);
            check("R10 data kept", 32'(rx_data), 32'(b));
        end

        // R9 filter off, stop bit 0 accepted
        stop_filter_en = 1'b0;
        send_frame(8'h3C, 1'b0);
        check("R9 data", 32'(rx_data), 32'h3C);
        check("R9 stop", 32'(rx_stop), 32'h0);
        check("R9 ready", 32'(rx_ready), 32'h1);
        clear_ready();

        // R8 filter on, stop bit 0 dropped
        stop_filter_en = 1'b1;
        send_frame(8'hC3, 1'b0);
        check("R8 drop ready", 32'(rx_ready), 32'h0);
        check("R8 drop data", 32'(rx_data), 32'h3C);
        check("R8 drop stop", 32'(rx_stop), 32'h0);
        stop_filter_en = 1'b0;

        // R7 overrun
        send_frame(8'h11, 1'b1);
        check("R7 first", 32'(rx_data), 32'h11);
        send_frame(8'h22, 1'b0);
        check("R7 overrun data", 32'(rx_data), 32'h11);
        check("R7 overrun stop", 32'(rx_stop), 32'h1);
        check("R7 overrun ready", 32'(rx_ready), 32'h1);
        clear_ready();

        // R12 previous byte readable during the next frame
        drive_bit(1'b0);
        for (int i = 0; i < 5; i++) drive_bit(i[0]);
        check("R12 mid-frame data", 32'(rx_data), 32'h11);
        for (int i = 5; i < 8; i++) drive_bit(i[0]);
        drive_bit(1'b1);
        rxd_in = 1'b1;
        repeat (6) @(negedge clk);
        check("R12 new data", 32'(rx_data), 32'hAA);
        clear_ready();

        // R3 one-tick-wide glitch inside bit 3 changes at most one vote
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) begin
                rxd_in = 1'b0;
                repeat (18) @(negedge clk);
                rxd_in = 1'b1;
                repeat (tick_div) @(negedge clk);
                rxd_in = 1'b0;
                repeat (16 * tick_div - 18 - tick_div) @(negedge clk);
            end else begin
                drive_bit(1'b0);
            end
        end
        drive_bit(1'b1);
        repeat (6) @(negedge clk);
        check("R3 glitch data", 32'(rx_data), 32'h00);
        check("R3 glitch ready", 32'(rx_ready), 32'h1);
        clear_ready();

        // R11 slower tick
        tick_div = 3;
        repeat (10) @(negedge clk);
        send_frame(8'h96, 1'b1);
        check("R11 slow tick data", 32'(rx_data), 32'h96);
        check("R11 slow tick ready", 32'(rx_ready), 32'h1);

        summary();
    end
endmodule